// File: doc/BRIEF.md
# Dual-Area Directional Mailbox Memory

The block is a shared memory that lets two processors pass bytes to each other. It holds two separate areas of 128 words by 8 bits. Each area carries traffic in one direction only. Port A writes area 1 and reads area 2. Port B writes area 2 and reads area 1. A processor leaves a message in its outgoing area, and the other side picks it up from its incoming area.

Each port has its own clock, synchronous active-low reset, active-low chip select, write enable and output enable, an 8-bit address, write data, read data and a drive-enable output. The drive-enable output stands in for the three-state control of a data bus. The two ports share no timing. Address bit 7 names the area, and bits 6 to 0 name the word inside it. An access that would carry data against the fixed direction of an area is dropped.

Top module: `dir_mailbox`

## Requirements
- R1: The address is 8 bits wide. Bit 7 chooses the area: 0 is area 1 and 1 is area 2. Bits 6..0 choose one of 128 words of 8 bits in that area.
- R2: A port-A write (cs_a_n=0, we_a_n=0, addr_a[7]=0) stores wdata_a at word addr_a[6:0] of area 1 on the rising clk_a edge. A later port-B read of address {1'b0, word} returns that byte.
- R3: A port-B write (cs_b_n=0, we_b_n=0, addr_b[7]=1) stores wdata_b at word addr_b[6:0] of area 2. A later port-A read of address {1'b1, word} returns that byte.
- R4: A write aimed at the area a port may not write has no effect on memory. This covers port A with addr_a[7]=1 and port B with addr_b[7]=0. A later read through the legal port returns the earlier contents.
- R5: A read aimed at the area a port may not read leaves the drive enable at 0 and the read data at 0x00. This covers port A with addr[7]=0 and port B with addr[7]=1.
- R6: The drive enable rises only in the cycle after a clock edge that sampled chip select=0, output enable=0, write enable=1 and a readable address. Write enable has priority over output enable, so a write cycle never drives the bus.
- R7: Read data and drive enable appear after the same rising edge that samples a legal read request, and they hold until the next edge. While the drive enable is 0, the read data is 0x00.
- R8: While a port's reset is low at a clock edge, that port's drive enable and read data are cleared to 0. Reset does not change memory contents.
- R9: The two ports run on unrelated clocks and may operate at the same time on different words without disturbing each other. If one port writes a word in the same cycle that the other port reads it, the value read is undefined: it may be the old byte or the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| cs_a_n | input | 1 | Port A chip select, active low |
| we_a_n | input | 1 | Port A write enable, active low |
| oe_a_n | input | 1 | Port A output enable, active low |
| addr_a | input | 8 | Port A address; bit 7 selects the area |
| wdata_a | input | 8 | Port A write data |
| rdata_a | output | 8 | Port A read data, 0 when not driving |
| rdata_oe_a | output | 1 | Port A data-bus drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| cs_b_n | input | 1 | Port B chip select, active low |
| we_b_n | input | 1 | Port B write enable, active low |
| oe_b_n | input | 1 | Port B output enable, active low |
| addr_b | input | 8 | Port B address; bit 7 selects the area |
| wdata_b | input | 8 | Port B write data |
| rdata_b | output | 8 | Port B read data, 0 when not driving |
| rdata_oe_b | output | 1 | Port B data-bus drive enable |

## Verification
Every word of both areas is filled through its writing port with an address-dependent pattern and read back through the other port. This separates a correct word decode from aliased or swapped words and from a swapped area select. A second full sweep writes the complemented pattern through the forbidden port, and every word is then read back unchanged, which exposes a leaking write gate. Forbidden-area reads, reads with write enable also asserted, and the cycles after a read are checked for a zero bus with the enable low. The remaining sequences are a mid-run reset followed by a full re-read, and a phase in which both ports work at once on disjoint words. They separate reset clearing of the output path from reset clearing of the storage, and they show that the ports stay independent across unrelated clocks.

// File: rtl/mbx_pkg.sv
// Package mbx_pkg
// Shared definitions for the directional mailbox: the number of ports and
// the decoded operation class of one port access.
// Assumes exactly two ports, where port p writes area p.
package mbx_pkg;

    localparam int MBX_PORTS = 2;

    // Decoded class of a single port access in one cycle.
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_READ    = 2'd2,
        OP_BLOCKED = 2'd3
    } mbx_op_e;

    // Index of the port on the other side of an area.
    function automatic int peer_of(input int p);
        return (MBX_PORTS - 1) - p;
    endfunction

endpackage

// File: rtl/mbx_port.sv
// Module mbx_port
// Decodes the access of one port into a write strobe for the area that port
// owns and a read strobe for the area it receives. It also holds the
// data-bus drive-enable register.
// Assumptions: control inputs are active low and synchronous to clk. An
// access against the fixed direction is classed as blocked and has no
// effect. Write enable takes priority over output enable.
module mbx_port #(
    parameter int ADDR_W   = 8,
    parameter bit OWN_AREA = 1'b0,
    localparam int WORD_W  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_en,
    output logic [WORD_W-1:0] word,
    output logic              drive_q
);
    import mbx_pkg::*;

    mbx_op_e op;
    logic    area_sel;

    assign area_sel = addr[ADDR_W-1];
    assign word     = addr[WORD_W-1:0];

    // Classify the current access from the control pins and the area bit.
    always_comb begin
        op = OP_IDLE;
        if (!cs_n) begin
            if (!we_n) begin
                op = (area_sel == OWN_AREA) ? OP_WRITE : OP_BLOCKED;
            end else if (!oe_n) begin
                op = (area_sel != OWN_AREA) ? OP_READ : OP_BLOCKED;
            end
        end
    end

    assign wr_en = (op == OP_WRITE);
    assign rd_en = (op == OP_READ);

    // Register the drive enable: it is high for the cycle after a legal read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= rd_en;
        end
    end

endmodule

// File: rtl/mbx_area.sv
// Module mbx_area
// One mailbox area. It has a write port on the clock of the sending side
// and a registered read port on the clock of the receiving side.
// Assumptions: storage is not reset. The read register is reset by the
// receiver's reset and loads 0 when no read is requested. A write and a read
// of the same word in overlapping cycles return an undefined value.
module mbx_area #(
    parameter int WORD_W  = 7,
    parameter int DATA_W  = 8,
    localparam int DEPTH  = 1 << WORD_W
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte from the sending side.
    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    // Fetch a byte for the receiving side, or load 0 when idle.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[raddr];
        end else begin
            rd_q <= '0;
        end
    end

endmodule

// File: rtl/dir_mailbox.sv
// Module dir_mailbox
// Two-port mailbox with two one-way areas. Port p writes area p and reads
// the area of its peer. Port A is p=0 and port B is p=1. The most
// significant address bit selects the area.
// Assumptions: each port runs on its own clock with its own synchronous
// active-low reset. The three-state bus is modelled as read data plus a
// drive enable.
module dir_mailbox #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    localparam int WORD_W = ADDR_W - 1
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              cs_a_n,
    input  logic              we_a_n,
    input  logic              oe_a_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    output logic              rdata_oe_a,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              cs_b_n,
    input  logic              we_b_n,
    input  logic              oe_b_n,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b,
    output logic              rdata_oe_b
);
    import mbx_pkg::*;

    logic [MBX_PORTS-1:0] clk_v, rst_v, cs_v, we_v, oe_v;
    logic [MBX_PORTS-1:0] wr_v, rd_v, drv_v;
    logic [ADDR_W-1:0]    addr_v  [MBX_PORTS];
    logic [DATA_W-1:0]    wdata_v [MBX_PORTS];
    logic [DATA_W-1:0]    rdq_v   [MBX_PORTS];
    logic [WORD_W-1:0]    word_v  [MBX_PORTS];

    // Gather the named pins into arrays indexed by port.
    assign clk_v = {clk_b, clk_a};
    assign rst_v = {rst_b_n, rst_a_n};
    assign cs_v  = {cs_b_n, cs_a_n};
    assign we_v  = {we_b_n, we_a_n};
    assign oe_v  = {oe_b_n, oe_a_n};
    assign addr_v[0]  = addr_a;
    assign addr_v[1]  = addr_b;
    assign wdata_v[0] = wdata_a;
    assign wdata_v[1] = wdata_b;

    // One port decoder and one area per side; area g is written by port g.
    for (genvar g = 0; g < MBX_PORTS; g++) begin : g_side
        localparam int PEER = peer_of(g);

        mbx_port #(
            .ADDR_W   (ADDR_W),
            .OWN_AREA (1'(g))
        ) u_port (
            .clk     (clk_v[g]),
            .rst_n   (rst_v[g]),
            .cs_n    (cs_v[g]),
            .we_n    (we_v[g]),
            .oe_n    (oe_v[g]),
            .addr    (addr_v[g]),
            .wr_en   (wr_v[g]),
            .rd_en   (rd_v[g]),
            .word    (word_v[g]),
            .drive_q (drv_v[g])
        );

        mbx_area #(
            .WORD_W (WORD_W),
            .DATA_W (DATA_W)
        ) u_area (
            .wr_clk   (clk_v[g]),
            .wr_en    (wr_v[g]),
            .waddr    (word_v[g]),
            .wdata    (wdata_v[g]),
            .rd_clk   (clk_v[PEER]),
            .rd_rst_n (rst_v[PEER]),
            .rd_en    (rd_v[PEER]),
            .raddr    (word_v[PEER]),
            .rd_q     (rdq_v[g])
        );
    end

    // Each port receives the data of the area its peer writes.
    assign rdata_a    = rdq_v[peer_of(0)];
    assign rdata_b    = rdq_v[peer_of(1)];
    assign rdata_oe_a = drv_v[0];
    assign rdata_oe_b = drv_v[1];

endmodule

// File: rtl/mbx_chk.sv
// Module mbx_chk
// Protocol checker for dir_mailbox, bound to every instance. For each port
// it checks the bus drive rules, forbidden-area reads and read latency, each
// on that port's own clock.
// Assumption: the port pins are observed at the top-level boundary.
module mbx_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic              cs_a_n,
    input logic              we_a_n,
    input logic              oe_a_n,
    input logic [ADDR_W-1:0] addr_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic              rdata_oe_a,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic              cs_b_n,
    input logic              we_b_n,
    input logic              oe_b_n,
    input logic [ADDR_W-1:0] addr_b,
    input logic [DATA_W-1:0] rdata_b,
    input logic              rdata_oe_b
);
    // R7: a legal read request on port A is driven after the next edge.
    assert_read_latency_a_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!cs_a_n && we_a_n && !oe_a_n && addr_a[ADDR_W-1]) |=> rdata_oe_a);

    // R7: port A carries zero data whenever it is not driving.
    assert_idle_zero_a_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !rdata_oe_a |-> (rdata_a == '0));

    // R6: a port A write cycle never drives the bus in the next cycle.
    assert_write_priority_a_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!cs_a_n && !we_a_n) |=> !rdata_oe_a);

    // R6: the port A drive enable only follows a sampled legal read.
    assert_drive_source_a_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        rdata_oe_a |-> $past(!cs_a_n && we_a_n && !oe_a_n && addr_a[ADDR_W-1]));

    // R5: a port A read of area 1 stays undriven.
    assert_blocked_read_a_R5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!cs_a_n && we_a_n && !oe_a_n && !addr_a[ADDR_W-1]) |=> !rdata_oe_a);

    // R7: a legal read request on port B is driven after the next edge.
    assert_read_latency_b_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!cs_b_n && we_b_n && !oe_b_n && !addr_b[ADDR_W-1]) |=> rdata_oe_b);

    // R7: port B carries zero data whenever it is not driving.
    assert_idle_zero_b_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !rdata_oe_b |-> (rdata_b == '0));

    // R6: a port B write cycle never drives the bus in the next cycle.
    assert_write_priority_b_R6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!cs_b_n && !we_b_n) |=> !rdata_oe_b);

    // R6: the port B drive enable only follows a sampled legal read.
    assert_drive_source_b_R6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        rdata_oe_b |-> $past(!cs_b_n && we_b_n && !oe_b_n && !addr_b[ADDR_W-1]));

    // R5: a port B read of area 2 stays undriven.
    assert_blocked_read_b_R5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!cs_b_n && we_b_n && !oe_b_n && addr_b[ADDR_W-1]) |=> !rdata_oe_b);

endmodule

bind dir_mailbox mbx_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk_a      (clk_a),
    .rst_a_n    (rst_a_n),
    .cs_a_n     (cs_a_n),
    .we_a_n     (we_a_n),
    .oe_a_n     (oe_a_n),
    .addr_a     (addr_a),
    .rdata_a    (rdata_a),
    .rdata_oe_a (rdata_oe_a),
    .clk_b      (clk_b),
    .rst_b_n    (rst_b_n),
    .cs_b_n     (cs_b_n),
    .we_b_n     (we_b_n),
    .oe_b_n     (oe_b_n),
    .addr_b     (addr_b),
    .rdata_b    (rdata_b),
    .rdata_oe_b (rdata_oe_b)
);

// File: tb/sim_dir_mailbox.sv
// Bench for dir_mailbox: full sweeps of both areas on two unrelated clocks.
// Inputs change on falling edges; outputs are sampled 1 ns after rising edges.
module sim_dir_mailbox;

    logic       clk_a = 1'b0, clk_b = 1'b0;
    logic       rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic       cs_a_n = 1'b1, we_a_n = 1'b1, oe_a_n = 1'b1;
    logic       cs_b_n = 1'b1, we_b_n = 1'b1, oe_b_n = 1'b1;
    logic [7:0] addr_a = '0, wdata_a = '0, addr_b = '0, wdata_b = '0;
    logic [7:0] rdata_a, rdata_b;
    logic       rdata_oe_a, rdata_oe_b;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk_a = ~clk_a;      // 250 MHz
    always #3.5 clk_b = ~clk_b;    // unrelated second clock

    dir_mailbox u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a_n(cs_a_n), .we_a_n(we_a_n),
        .oe_a_n(oe_a_n), .addr_a(addr_a), .wdata_a(wdata_a),
        .rdata_a(rdata_a), .rdata_oe_a(rdata_oe_a),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b_n(cs_b_n), .we_b_n(we_b_n),
        .oe_b_n(oe_b_n), .addr_b(addr_b), .wdata_b(wdata_b),
        .rdata_b(rdata_b), .rdata_oe_b(rdata_oe_b)
    );

    function automatic logic [7:0] pat_a(input int i);
        return 8'((i * 37 + 5) % 256);
    endfunction

    function automatic logic [7:0] pat_b(input int i);
        return 8'((i * 91 + 3) % 256) ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_write(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk_a);
        cs_a_n = 1'b0; we_a_n = 1'b0; addr_a = ad; wdata_a = d;
        @(negedge clk_a);
        cs_a_n = 1'b1; we_a_n = 1'b1;
    endtask

    task automatic b_write(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk_b);
        cs_b_n = 1'b0; we_b_n = 1'b0; addr_b = ad; wdata_b = d;
        @(negedge clk_b);
        cs_b_n = 1'b1; we_b_n = 1'b1;
    endtask

    task automatic a_read(input logic [7:0] ad, output logic [7:0] d, output logic oe);
        @(negedge clk_a);
        cs_a_n = 1'b0; oe_a_n = 1'b0; addr_a = ad;
        @(posedge clk_a); #1;
        d = rdata_a; oe = rdata_oe_a;
        @(negedge clk_a);
        cs_a_n = 1'b1; oe_a_n = 1'b1;
    endtask

    task automatic b_read(input logic [7:0] ad, output logic [7:0] d, output logic oe);
        @(negedge clk_b);
        cs_b_n = 1'b0; oe_b_n = 1'b0; addr_b = ad;
        @(posedge clk_b); #1;
        d = rdata_b; oe = rdata_oe_b;
        @(negedge clk_b);
        cs_b_n = 1'b1; oe_b_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk_a);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;

        // R8: output path is cleared while reset is held.
        repeat (4) @(posedge clk_b);
        #1;
        check("R8 reset oe_a", {7'b0, rdata_oe_a}, 8'h00);
        check("R8 reset rdata_a", rdata_a, 8'h00);
        check("R8 reset oe_b", {7'b0, rdata_oe_b}, 8'h00);
        check("R8 reset rdata_b", rdata_b, 8'h00);
        @(negedge clk_a); rst_a_n = 1'b1;
        @(negedge clk_b); rst_b_n = 1'b1;

        // R1/R2: fill area 1 from A, read every word from B.
        for (int i = 0; i < 128; i++) a_write(8'(i), pat_a(i));
        for (int i = 0; i < 128; i++) begin
            b_read(8'(i), d, oe);
            check("R2 B reads area1 data", d, pat_a(i));
            check("R7 B read drive enable", {7'b0, oe}, 8'h01);
        end

        // R1/R3: fill area 2 from B, read every word from A.
        for (int i = 0; i < 128; i++) b_write(8'(128 + i), pat_b(i));
        for (int i = 0; i < 128; i++) begin
            a_read(8'(128 + i), d, oe);
            check("R3 A reads area2 data", d, pat_b(i));
            check("R7 A read drive enable", {7'b0, oe}, 8'h01);
        end

        // R4: forbidden writes leave both areas unchanged.
        for (int i = 0; i < 128; i++) a_write(8'(128 + i), ~pat_b(i));
        for (int i = 0; i < 128; i++) b_write(8'(i), ~pat_a(i));
        for (int i = 0; i < 128; i++) begin
            a_read(8'(128 + i), d, oe);
            check("R4 area2 kept after A write", d, pat_b(i));
            b_read(8'(i), d, oe);
            check("R4 area1 kept after B write", d, pat_a(i));
        end

        // R5: forbidden reads stay undriven and zero.
        for (int i = 0; i < 128; i += 9) begin
            a_read(8'(i), d, oe);
            check("R5 A read area1 data", d, 8'h00);
            check("R5 A read area1 oe", {7'b0, oe}, 8'h00);
            b_read(8'(128 + i), d, oe);
            check("R5 B read area2 data", d, 8'h00);
            check("R5 B read area2 oe", {7'b0, oe}, 8'h00);
        end

        // R6: write enable beats output enable on a readable address.
        @(negedge clk_a);
        cs_a_n = 1'b0; we_a_n = 1'b0; oe_a_n = 1'b0; addr_a = 8'd140; wdata_a = 8'hEE;
        @(posedge clk_a); #1;
        check("R6 A write+oe no drive", {7'b0, rdata_oe_a}, 8'h00);
        check("R6 A write+oe zero data", rdata_a, 8'h00);
        @(negedge clk_a);
        cs_a_n = 1'b1; we_a_n = 1'b1; oe_a_n = 1'b1;
        @(negedge clk_b);
        cs_b_n = 1'b0; we_b_n = 1'b0; oe_b_n = 1'b0; addr_b = 8'd20; wdata_b = 8'hEE;
        @(posedge clk_b); #1;
        check("R6 B write+oe no drive", {7'b0, rdata_oe_b}, 8'h00);
        @(negedge clk_b);
        cs_b_n = 1'b1; we_b_n = 1'b1; oe_b_n = 1'b1;
        a_read(8'd140, d, oe);
        check("R6 area2 unchanged by blocked write", d, pat_b(12));

        // R7: the cycle after a read returns to idle zero.
        a_read(8'd130, d, oe);
        check("R7 A read data", d, pat_b(2));
        @(posedge clk_a); #1;
        check("R7 A idle oe", {7'b0, rdata_oe_a}, 8'h00);
        check("R7 A idle data", rdata_a, 8'h00);
        b_read(8'd3, d, oe);
        @(posedge clk_b); #1;
        check("R7 B idle data", rdata_b, 8'h00);

        // R8: reset during a pending read clears the output, keeps memory.
        @(negedge clk_a);
        rst_a_n = 1'b0; cs_a_n = 1'b0; oe_a_n = 1'b0; addr_a = 8'd129;
        @(posedge clk_a); #1;
        check("R8 A reset overrides read oe", {7'b0, rdata_oe_a}, 8'h00);
        check("R8 A reset overrides read data", rdata_a, 8'h00);
        @(negedge clk_a);
        cs_a_n = 1'b1; oe_a_n = 1'b1; rst_a_n = 1'b1;
        @(negedge clk_b); rst_b_n = 1'b0;
        repeat (2) @(negedge clk_b);
        rst_b_n = 1'b1;
        for (int i = 0; i < 128; i += 5) begin
            a_read(8'(128 + i), d, oe);
            check("R8 area2 survives reset", d, pat_b(i));
            b_read(8'(i), d, oe);
            check("R8 area1 survives reset", d, pat_a(i));
        end

        // R9: concurrent traffic on disjoint words of area 1.
        fork
            for (int i = 64; i < 128; i++) a_write(8'(i), pat_b(i));
            for (int i = 0; i < 64; i++) begin
                logic [7:0] dd;
                logic       oo;
                b_read(8'(i), dd, oo);
                check("R9 B read during A writes", dd, pat_a(i));
            end
        join
        for (int i = 64; i < 128; i++) begin
            b_read(8'(i), d, oe);
            check("R9 A concurrent writes landed", d, pat_b(i));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule